// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks divider settings for a clock synthesiser. It takes a reference frequency, a wanted output frequency, a VCO window and the legal ranges of the input divider M, the feedback divider N and the post-divider shift. From these it returns the (M, N, shift) triple whose VCO frequency lands nearest to the target. The block runs as a sequential search. It uses one shared shift-subtract divider for every quotient. A single start strobe launches the search, and a one-cycle done pulse reports the result.

The search runs in three phases. First it doubles the target as far as the shift limit and the VCO ceiling allow. Then it clamps the target into the VCO window. Last it walks the post shift from its highest value down to zero. At each shift value it sweeps M upward and computes a rounded N for every M. The target and the best error found so far are both halved at each shift step, so candidates at different shifts are compared on the same scale. All frequencies are unsigned kHz values.

Top module: `pll_div_search`

## Requirements
- R1: Before the sweep, the target is doubled while the doubling count stays at or below `shift_max` and twice the target stays at or below `vco_max_khz`. The doubling count is the first shift tried, so a reported `best_shift` never exceeds `shift_max`.
- R2: After doubling, a target below `vco_min_khz` is raised to it. The result, if above `vco_max_khz`, is then lowered to it.
- R3: The shift is tried from its first value down to 0. After each shift step the target and the best error are each shifted right by one bit. The sweep ends as soon as the target at the start of a step is below `vco_min_khz`.
- R4: For each M from `m_lo` to `m_hi`, the quotient q = floor((target*(M+1) + floor(ref/2)) / ref) is formed, and N = q - 1.
- R5: If q is 0 or q - 1 exceeds `n_hi`, the M sweep for the current shift ends. If N is below `n_lo`, N is set to `n_lo`.
- R6: The candidate VCO frequency is floor(ref*(N+1)/(M+1)). Its error is the absolute difference from the current target.
- R7: The best error starts as a 40-bit all-ones value. A candidate is kept only when its error is strictly smaller, so the earliest candidate wins a tie.
- R8: If no candidate is kept, `no_fit` is 1 and `vco_khz`, `best_m`, `best_n` and `best_shift` are 0 when done pulses. Otherwise `no_fit` is 0.
- R9: While `busy` is 1, `start` and all configuration inputs are ignored. The result depends only on the inputs present at the accepted start.
- R10: `done` is high for exactly one cycle per search. `busy` is 1 from the cycle after an accepted start until `done` rises.
- R11: After reset, `busy`, `done`, `no_fit` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a search when idle |
| ref_khz | input | FW | Reference frequency |
| want_khz | input | FW | Wanted output frequency |
| vco_max_khz | input | FW | VCO ceiling |
| vco_min_khz | input | FW | VCO floor |
| m_lo | input | DW | Smallest input divider value |
| m_hi | input | DW | Largest input divider value |
| n_lo | input | DW | Smallest feedback divider value |
| n_hi | input | DW | Largest feedback divider value |
| shift_max | input | PW | Largest post-divider shift |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| best_m | output | DW | Chosen input divider |
| best_n | output | DW | Chosen feedback divider |
| best_shift | output | PW | Chosen post shift |
| vco_khz | output | FW+DW | Achieved VCO frequency, 0 when no fit |
| no_fit | output | 1 | No candidate was accepted |

## Verification
Two reference setups are swept across many wanted frequencies, each compared against an arithmetic model.
- The first setup, with a wide N range, mostly exercises rounding, doubling and halving.
- The second, with a narrow N range, forces both the N floor clamp and the early end of the M sweep.

Four targeted cases cover the remaining paths:
- A shift limit of zero checks that doubling stops at the limit.
- A floor above the ceiling leaves no candidate.
- An N ceiling that every candidate exceeds also leaves no candidate.
- A start pulse with a different configuration mid-search must leave the first result untouched.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_CLAMP, S_PCHK, S_MCHK, S_DIVN, S_DIVV, S_PEND, S_FIN
  } srch_state_t;
endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         valid,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q, den_q, num_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, valid_q;

  wire [W:0] rem_sh = {rem_q[W-1:0], quo_q[W-1]};
  wire       fits   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0; num_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (go && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= CW'(W);
        rem_q <= '0;
        quo_q <= num;
        num_q <= num;
        den_q <= den;
      end else if (run_q) begin
        rem_q <= fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q   <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign valid = valid_q;
  assign quo   = quo_q;

  // R4: quotient and remainder satisfy the division identity bounds
  p_div_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (((2*W)'(quo_q) * (2*W)'(den_q)) <= (2*W)'(num_q)) && (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep #(
  parameter int DW  = 8,
  parameter int PW  = 3,
  parameter int VW  = 32,
  parameter int PRW = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init,
  input  logic           halve,
  input  logic           offer,
  input  logic [PRW-1:0] cand_diff,
  input  logic [DW-1:0]  cand_m,
  input  logic [DW-1:0]  cand_n,
  input  logic [PW-1:0]  cand_p,
  input  logic [VW-1:0]  cand_vco,
  output logic           accept,
  output logic           found,
  output logic [DW-1:0]  best_m,
  output logic [DW-1:0]  best_n,
  output logic [PW-1:0]  best_p,
  output logic [VW-1:0]  best_vco
);
  logic [PRW-1:0] err_q;

  assign accept = offer && (cand_diff < err_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '1; found <= 1'b0;
      best_m <= '0; best_n <= '0; best_p <= '0; best_vco <= '0;
    end else if (init) begin
      err_q <= '1; found <= 1'b0;
      best_m <= '0; best_n <= '0; best_p <= '0; best_vco <= '0;
    end else if (accept) begin
      err_q <= cand_diff; found <= 1'b1;
      best_m <= cand_m; best_n <= cand_n; best_p <= cand_p; best_vco <= cand_vco;
    end else if (halve) begin
      err_q <= err_q >> 1;
    end
  end

  // R7: outside a restart the best error never grows
  p_err_nonrise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> (err_q <= $past(err_q)));
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int FW  = 24,
  parameter int DW  = 8,
  parameter int PW  = 3,
  parameter int PRW = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FW-1:0]    ref_khz,
  input  logic [FW-1:0]    want_khz,
  input  logic [FW-1:0]    vco_max_khz,
  input  logic [FW-1:0]    vco_min_khz,
  input  logic [DW-1:0]    m_lo,
  input  logic [DW-1:0]    m_hi,
  input  logic [DW-1:0]    n_lo,
  input  logic [DW-1:0]    n_hi,
  input  logic [PW-1:0]    shift_max,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    best_m,
  output logic [DW-1:0]    best_n,
  output logic [PW-1:0]    best_shift,
  output logic [FW+DW-1:0] vco_khz,
  output logic             no_fit
);
  localparam int VW = FW + DW;

  function automatic logic [PRW-1:0] round_num(input logic [FW-1:0] t, input logic [DW:0] m,
                                                input logic [FW-1:0] r);
    return PRW'(t) * (PRW'(m) + PRW'(1)) + PRW'(r >> 1);
  endfunction

  function automatic logic [PRW-1:0] vco_num(input logic [FW-1:0] r, input logic [DW-1:0] n);
    return PRW'(r) * (PRW'(n) + PRW'(1));
  endfunction

  function automatic logic [PRW-1:0] abs_gap(input logic [PRW-1:0] a, input logic [PRW-1:0] b);
    return (a < b) ? (b - a) : (a - b);
  endfunction

  srch_state_t st_q;
  logic [FW-1:0] ref_q, max_q, min_q, t_q;
  logic [DW-1:0] mlo_q, mhi_q, nlo_q, nhi_q, n_q;
  logic [PW-1:0] pmax_q, p_q;
  logic [DW:0]   m_q;
  logic          done_q, no_fit_q;
  logic [DW-1:0] out_m_q, out_n_q;
  logic [PW-1:0] out_p_q;
  logic [VW-1:0] out_vco_q;

  // Named internal events
  logic           div_go, div_valid, n_cap, keep_init, keep_halve, keep_offer, keep_accept;
  logic [PRW-1:0] div_num, div_den, div_q, q_m1;
  logic [DW-1:0]  n_pick;
  logic           k_found;
  logic [DW-1:0]  k_m, k_n;
  logic [PW-1:0]  k_p;
  logic [VW-1:0]  k_vco;
  logic [FW-1:0]  t_raised;

  assign q_m1     = div_q - PRW'(1);
  assign n_cap    = (div_q == '0) || (q_m1 > PRW'(nhi_q));
  assign n_pick   = (q_m1 < PRW'(nlo_q)) ? nlo_q : q_m1[DW-1:0];
  assign t_raised = (t_q < min_q) ? min_q : t_q;

  assign div_go = ((st_q == S_MCHK) && (m_q <= {1'b0, mhi_q})) ||
                  ((st_q == S_DIVN) && div_valid && !n_cap);
  assign div_num = (st_q == S_DIVN) ? vco_num(ref_q, n_pick) : round_num(t_q, m_q, ref_q);
  assign div_den = (st_q == S_DIVN) ? PRW'(m_q) + PRW'(1) : PRW'(ref_q);

  assign keep_init  = (st_q == S_CLAMP);
  assign keep_halve = (st_q == S_PEND);
  assign keep_offer = (st_q == S_DIVV) && div_valid;

  pll_seq_div #(.W(PRW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .valid(div_valid), .quo(div_q)
  );

  pll_best_keep #(.DW(DW), .PW(PW), .VW(VW), .PRW(PRW)) u_keep (
    .clk(clk), .rst_n(rst_n), .init(keep_init), .halve(keep_halve), .offer(keep_offer),
    .cand_diff(abs_gap(div_q, PRW'(t_q))), .cand_m(m_q[DW-1:0]), .cand_n(n_q),
    .cand_p(p_q), .cand_vco(div_q[VW-1:0]), .accept(keep_accept), .found(k_found),
    .best_m(k_m), .best_n(k_n), .best_p(k_p), .best_vco(k_vco)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      ref_q <= '0; max_q <= '0; min_q <= '0; t_q <= '0;
      mlo_q <= '0; mhi_q <= '0; nlo_q <= '0; nhi_q <= '0; n_q <= '0;
      pmax_q <= '0; p_q <= '0; m_q <= '0;
      done_q <= 1'b0; no_fit_q <= 1'b0;
      out_m_q <= '0; out_n_q <= '0; out_p_q <= '0; out_vco_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin
          ref_q <= ref_khz; max_q <= vco_max_khz; min_q <= vco_min_khz;
          mlo_q <= m_lo; mhi_q <= m_hi; nlo_q <= n_lo; nhi_q <= n_hi;
          pmax_q <= shift_max; t_q <= want_khz; p_q <= '0;
          st_q <= S_PRE;
        end
        S_PRE: if ((p_q < pmax_q) && ({t_q, 1'b0} <= {1'b0, max_q})) begin
          t_q <= t_q << 1;
          p_q <= p_q + 1'b1;
        end else begin
          st_q <= S_CLAMP;
        end
        S_CLAMP: begin
          t_q  <= (t_raised > max_q) ? max_q : t_raised;
          st_q <= S_PCHK;
        end
        S_PCHK: if (t_q < min_q) st_q <= S_FIN;
                else begin m_q <= {1'b0, mlo_q}; st_q <= S_MCHK; end
        S_MCHK: st_q <= (m_q > {1'b0, mhi_q}) ? S_PEND : S_DIVN;
        S_DIVN: if (div_valid) begin
          if (n_cap) st_q <= S_PEND;
          else begin n_q <= n_pick; st_q <= S_DIVV; end
        end
        S_DIVV: if (div_valid) begin
          m_q  <= m_q + 1'b1;
          st_q <= S_MCHK;
        end
        S_PEND: begin
          t_q <= t_q >> 1;
          if (p_q == '0) st_q <= S_FIN;
          else begin p_q <= p_q - 1'b1; st_q <= S_PCHK; end
        end
        S_FIN: begin
          done_q    <= 1'b1;
          no_fit_q  <= !k_found;
          out_m_q   <= k_m;
          out_n_q   <= k_n;
          out_p_q   <= k_p;
          out_vco_q <= k_found ? k_vco : '0;
          st_q      <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign done       = done_q;
  assign best_m     = out_m_q;
  assign best_n     = out_n_q;
  assign best_shift = out_p_q;
  assign vco_khz    = out_vco_q;
  assign no_fit     = no_fit_q;

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: no fit reports a zero VCO frequency
  p_nofit_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && no_fit_q) |-> (out_vco_q == '0));
  // R1: reported shift within the limit
  p_shift_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !no_fit_q) |-> (out_p_q <= pmax_q));
  // R5: every offered N lies inside the legal range
  p_n_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    keep_offer |-> ((n_q >= nlo_q) && (n_q <= nhi_q)));
  // R9: configuration held while searching
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ref_q) && $stable(max_q) && $stable(min_q) &&
                               $stable(nhi_q) && $stable(pmax_q)));
endmodule

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
  localparam int FW = 24, DW = 8, PW = 3, VW = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [FW-1:0] ref_khz = '0, want_khz = '0, vco_max_khz = '0, vco_min_khz = '0;
  logic [DW-1:0] m_lo = '0, m_hi = '0, n_lo = '0, n_hi = '0;
  logic [PW-1:0] shift_max = '0;
  logic busy, done, no_fit;
  logic [DW-1:0] best_m, best_n;
  logic [PW-1:0] best_shift;
  logic [VW-1:0] vco_khz;

  int checks = 0, failures = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pll_div_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_khz(ref_khz), .want_khz(want_khz),
    .vco_max_khz(vco_max_khz), .vco_min_khz(vco_min_khz), .m_lo(m_lo), .m_hi(m_hi),
    .n_lo(n_lo), .n_hi(n_hi), .shift_max(shift_max), .busy(busy), .done(done),
    .best_m(best_m), .best_n(best_n), .best_shift(best_shift), .vco_khz(vco_khz), .no_fit(no_fit)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Independent arithmetic model; packs {no_fit, shift, m, n, vco}
  function automatic logic [63:0] model(input longint fr, input longint want, input longint fmax,
                                        input longint vmin, input longint mlo, input longint mhi,
                                        input longint nlo, input longint nhi, input longint pmax);
    longint t = want, p = 0, best = (longint'(1) << 40) - 1;
    longint bm = 0, bn = 0, bp = 0, bv = 0;
    bit hit = 0;
    while (p < pmax && t * 2 <= fmax) begin t = t * 2; p++; end
    if (t < vmin) t = vmin;
    if (t > fmax) t = fmax;
    forever begin
      if (t < vmin) break;
      for (longint m = mlo; m <= mhi; m++) begin
        longint q = (t * (m + 1) + fr / 2) / fr;
        longint n, f, d;
        if (q == 0 || q - 1 > nhi) break;
        n = (q - 1 < nlo) ? nlo : q - 1;
        f = fr * (n + 1) / (m + 1);
        d = (f > t) ? f - t : t - f;
        if (d < best) begin best = d; bm = m; bn = n; bp = p; bv = f; hit = 1; end
      end
      t = t >> 1; best = best >> 1;
      if (p == 0) break;
      p--;
    end
    if (!hit) return {12'd0, 1'b1, 3'd0, 8'd0, 8'd0, 32'd0};
    return {12'd0, 1'b0, bp[2:0], bm[7:0], bn[7:0], bv[31:0]};
  endfunction

  function automatic logic [63:0] got();
    return {12'd0, no_fit, best_shift, best_m, best_n, vco_khz};
  endfunction

  task automatic setcfg(input int fr, input int w, input int fmx, input int vmn, input int mlo,
                        input int mhi, input int nlo, input int nhi, input int pm);
    ref_khz = FW'(fr); want_khz = FW'(w); vco_max_khz = FW'(fmx); vco_min_khz = FW'(vmn);
    m_lo = DW'(mlo); m_hi = DW'(mhi); n_lo = DW'(nlo); n_hi = DW'(nhi); shift_max = PW'(pm);
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (!done) chk({tag, " timeout"}, 64'd0, 64'd1);
  endtask

  task automatic search(input string tag, input int fr, input int w, input int fmx, input int vmn,
                        input int mlo, input int mhi, input int nlo, input int nhi, input int pm);
    logic [63:0] exp;
    exp = model(fr, w, fmx, vmn, mlo, mhi, nlo, nhi, pm);
    setcfg(fr, w, fmx, vmn, mlo, mhi, nlo, nhi, pm);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk({tag, " R10 busy"}, 64'(busy), 64'd1);
    wait_done(tag);
    chk(tag, got(), exp);
    @(negedge clk);
    chk({tag, " R10 pulse"}, 64'(done), 64'd0);
  endtask

  initial begin
    while (cyc < 190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] exp;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset", {busy, done, no_fit, best_m, best_n, best_shift, vco_khz}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R3 R4 R6 R7: wide N range sweep
    for (int i = 0; i < 10; i++)
      search("R1 R3 R4 R6 R7 sweepA", 14318, 6000 + i * 21377, 220000, 50000, 1, 6, 7, 127, 3);
    // R5 R2: narrow N range, clamps and early M exit
    for (int i = 0; i < 8; i++)
      search("R5 R2 sweepB", 27000, 40000 + i * 33001, 300000, 100000, 2, 5, 20, 60, 2);
    // R1: zero shift limit, target clamped up to the floor
    search("R1 R2 noshift", 14318, 30000, 220000, 50000, 1, 4, 7, 127, 0);
    // R8: floor above ceiling leaves nothing
    search("R8 window", 14318, 100000, 90000, 120000, 1, 4, 7, 127, 3);
    // R8 R5: N ceiling exceeded for every M
    search("R8 R5 ncap", 14318, 150000, 220000, 50000, 1, 4, 1, 3, 2);
    // R9: start with another configuration during a search is ignored
    exp = model(14318, 77000, 220000, 50000, 1, 6, 7, 127, 3);
    setcfg(14318, 77000, 220000, 50000, 1, 6, 7, 127, 3);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    setcfg(27000, 12345, 300000, 100000, 2, 3, 20, 40, 1);
    chk("R9 busy before", 64'(busy), 64'd1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done("R9");
    chk("R9 result", got(), exp);
    @(negedge clk);
    chk("R9 no restart", 64'(busy), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule